// File: doc/BRIEF.md
# DDR2 Row-Cycle Timing Checker

This block sits beside a DDR2-style command bus and judges every command against the row-cycle rules. It decodes four command types from the strobes: activate, read, write and precharge. For each of eight banks it tracks whether a row is open and runs a set of saturating down-counters. A shared counter covers the spacing between activates to different banks. Column commands are timed at their internal issue point, which is the bus cycle plus the additive latency, and not at the bus cycle itself.

The timing values come in on configuration inputs. They are captured once, in the first clock after reset is released. Every command is checked on the edge that samples it. One cycle later a flag pulses together with a 3-bit reason code. A command that breaks a rule is still applied to the bank state, so checking of the commands that follow goes on as normal. An open-bank vector and the open row of every bank are available at all times.

Top module: `ddr_act_timing_chk`

## Requirements
- R1: Commands are decoded on a rising edge with cs_n low, using {ras_n,cas_n,we_n}: 011 activate, 101 read, 100 write, 010 precharge. With cs_n high, or any other strobe pattern, the cycle changes no state and raises no flag.
- R2: An activate to bank b sets bit b of bank_open and stores the row in bank_row[b*16 +: 16]. Both are visible in the cycle after the command.
- R3: A precharge to an open bank clears its bank_open bit. A precharge to a closed bank changes nothing and raises no flag.
- R4: An activate to a bank that is already open gives reason 1. The bank stays open with the new row.
- R5: An activate fewer than tRC cycles after the previous activate to the same bank gives reason 2. A gap of exactly tRC is legal.
- R6: An activate fewer than tRP cycles after a precharge that closed that bank gives reason 3.
- R7: An activate fewer than tRRD cycles after an activate to any bank gives reason 4.
- R8: A precharge fewer than tRAS cycles after the activate of that bank gives reason 5. The bank still closes.
- R9: A read or write to a closed bank gives reason 6.
- R10: A read or write at bus distance k from its activate gives reason 7 when k plus AL is less than tRCD. AL values above 4 act as 4.
- R11: An activate that breaks several rules reports the first that applies in the order reason 1, 2, 3, 4.
- R12: viol is high for exactly the cycle after a failing command, with viol_code holding the reason. When there is no violation, viol_code is 0.
- R13: The timing inputs are captured in the first clock after reset release. Later changes to them have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write strobe |
| bank | input | 3 | Bank address |
| row | input | 16 | Row address |
| cfg_trcd | input | 5 | Activate-to-column minimum |
| cfg_tras | input | 5 | Activate-to-precharge minimum |
| cfg_trp | input | 5 | Precharge-to-activate minimum |
| cfg_trc | input | 5 | Same-bank activate spacing |
| cfg_trrd | input | 5 | Any-bank activate spacing |
| cfg_al | input | 3 | Additive latency, 0 to 4 |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Reason code, 0 when no violation |
| bank_open | output | 8 | Open flag per bank |
| bank_row | output | 128 | Open row per bank, 16 bits each |

## Verification
On a single activate, several rules can fail in the same cycle. Examples are an activate to a bank still inside both its tRC and tRP windows, and an activate to an open bank issued inside tRRD. Directed sequences place a precharge and a re-activate back to back to provoke these overlaps. Random traffic over a few banks with short gaps provokes them many more times. The reported code is judged against a bench model that walks the reasons in priority order.

// File: rtl/ddr_act_pkg.sv
package ddr_act_pkg;
  localparam int TW = 5;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    RSN_OK         = 3'd0,
    RSN_ACT_OPEN   = 3'd1,
    RSN_ACT_RC     = 3'd2,
    RSN_ACT_RP     = 3'd3,
    RSN_ACT_RRD    = 3'd4,
    RSN_PRE_RAS    = 3'd5,
    RSN_COL_CLOSED = 3'd6,
    RSN_COL_RCD    = 3'd7
  } rsn_e;
endpackage

// File: rtl/ddr_rst_sync.sv
module ddr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q = sync_q[STAGES-1];
endmodule

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_act_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NONE;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        default: cmd = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ddr_bank_ctr.sv
module ddr_bank_ctr #(
  parameter int TW    = 5,
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [TW-1:0]    ras_ld,
  input  logic [TW-1:0]    rc_ld,
  input  logic [TW-1:0]    rcd_ld,
  input  logic [TW-1:0]    rp_ld,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic [TW-1:0]    ras_o,
  output logic [TW-1:0]    rc_o,
  output logic [TW-1:0]    rcd_o,
  output logic [TW-1:0]    rp_o
);
  logic          open_q, open_d;
  logic [TW-1:0] ras_q, ras_d, rc_q, rc_d, rcd_q, rcd_d, rp_q, rp_d;
  logic [ROW_W-1:0] row_q;

  function automatic logic [TW-1:0] tick(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  always_comb begin
    open_d = open_q;
    ras_d  = tick(ras_q);
    rc_d   = tick(rc_q);
    rcd_d  = tick(rcd_q);
    rp_d   = tick(rp_q);
    if (act_i) begin
      open_d = 1'b1;
      ras_d  = ras_ld;
      rc_d   = rc_ld;
      rcd_d  = rcd_ld;
    end else if (pre_i && open_q) begin
      open_d = 1'b0;
      rp_d   = rp_ld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      ras_q  <= '0;
      rc_q   <= '0;
      rcd_q  <= '0;
      rp_q   <= '0;
    end else begin
      open_q <= open_d;
      ras_q  <= ras_d;
      rc_q   <= rc_d;
      rcd_q  <= rcd_d;
      rp_q   <= rp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     row_q <= '0;
    else if (act_i) row_q <= row_i;
  end

  assign open_o = open_q;
  assign row_o  = row_q;
  assign ras_o  = ras_q;
  assign rc_o   = rc_q;
  assign rcd_o  = rcd_q;
  assign rp_o   = rp_q;
endmodule

// File: rtl/ddr_act_timing_chk.sv
module ddr_act_timing_chk
  import ddr_act_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = $clog2(NUM_BANKS),
  parameter int ROW_W     = 16,
  parameter int T_W       = ddr_act_pkg::TW,
  parameter int AL_W      = 3,
  parameter int AL_MAX    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BANK_W-1:0]          bank,
  input  logic [ROW_W-1:0]           row,
  input  logic [T_W-1:0]             cfg_trcd,
  input  logic [T_W-1:0]             cfg_tras,
  input  logic [T_W-1:0]             cfg_trp,
  input  logic [T_W-1:0]             cfg_trc,
  input  logic [T_W-1:0]             cfg_trrd,
  input  logic [AL_W-1:0]            cfg_al,
  output logic                       viol,
  output logic [2:0]                 viol_code,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row
);
  localparam logic [AL_W-1:0] AL_CAP = AL_W'(AL_MAX);

  logic rst_q;
  cmd_e cmd;

  ddr_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));
  ddr_cmd_decode u_dec (.cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd));

  // configuration capture, first clock after reset release
  logic            cap_done_q;
  logic [T_W-1:0]  trcd_q, tras_q, trp_q, trc_q, trrd_q;
  logic [AL_W-1:0] al_q;
  logic [T_W-1:0]  trcd_e, tras_e, trp_e, trc_e, trrd_e;
  logic [AL_W-1:0] al_e, al_use;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cap_done_q <= 1'b0;
      trcd_q <= '0; tras_q <= '0; trp_q <= '0; trc_q <= '0; trrd_q <= '0; al_q <= '0;
    end else if (!cap_done_q) begin
      cap_done_q <= 1'b1;
      trcd_q <= cfg_trcd; tras_q <= cfg_tras; trp_q <= cfg_trp;
      trc_q  <= cfg_trc;  trrd_q <= cfg_trrd; al_q  <= cfg_al;
    end
  end

  always_comb begin
    trcd_e = cap_done_q ? trcd_q : cfg_trcd;
    tras_e = cap_done_q ? tras_q : cfg_tras;
    trp_e  = cap_done_q ? trp_q  : cfg_trp;
    trc_e  = cap_done_q ? trc_q  : cfg_trc;
    trrd_e = cap_done_q ? trrd_q : cfg_trrd;
    al_e   = cap_done_q ? al_q   : cfg_al;
    al_use = (al_e > AL_CAP) ? AL_CAP : al_e;
  end

  function automatic logic [T_W-1:0] minus1(input logic [T_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  // per-bank trackers
  logic [T_W-1:0] ras_c [NUM_BANKS];
  logic [T_W-1:0] rc_c  [NUM_BANKS];
  logic [T_W-1:0] rcd_c [NUM_BANKS];
  logic [T_W-1:0] rp_c  [NUM_BANKS];
  logic [NUM_BANKS-1:0] open_v;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    assign hit = (bank == BANK_W'(g));
    ddr_bank_ctr #(.TW(T_W), .ROW_W(ROW_W)) u_bank (
      .clk(clk), .rst_n(rst_q),
      .act_i(hit && (cmd == CMD_ACT)),
      .pre_i(hit && (cmd == CMD_PRE)),
      .row_i(row),
      .ras_ld(minus1(tras_e)), .rc_ld(minus1(trc_e)),
      .rcd_ld(minus1(trcd_e)), .rp_ld(minus1(trp_e)),
      .open_o(open_v[g]), .row_o(bank_row[g*ROW_W +: ROW_W]),
      .ras_o(ras_c[g]), .rc_o(rc_c[g]), .rcd_o(rcd_c[g]), .rp_o(rp_c[g])
    );
  end

  // any-bank activate spacing
  logic [T_W-1:0] rrd_q, rrd_d;
  always_comb begin
    rrd_d = minus1(rrd_q);
    if (cmd == CMD_ACT) rrd_d = minus1(trrd_e);
  end
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) rrd_q <= '0;
    else        rrd_q <= rrd_d;
  end

  // rule evaluation for the addressed bank
  rsn_e rsn;
  always_comb begin
    rsn = RSN_OK;
    case (cmd)
      CMD_ACT: begin
        if (open_v[bank])            rsn = RSN_ACT_OPEN;
        else if (rc_c[bank] != '0)   rsn = RSN_ACT_RC;
        else if (rp_c[bank] != '0)   rsn = RSN_ACT_RP;
        else if (rrd_q != '0)        rsn = RSN_ACT_RRD;
      end
      CMD_PRE: begin
        if (open_v[bank] && (ras_c[bank] != '0)) rsn = RSN_PRE_RAS;
      end
      CMD_RD, CMD_WR: begin
        if (!open_v[bank]) rsn = RSN_COL_CLOSED;
        else if (rcd_c[bank] > {{(T_W-AL_W){1'b0}}, al_use}) rsn = RSN_COL_RCD;
      end
      default: rsn = RSN_OK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      viol      <= 1'b0;
      viol_code <= '0;
    end else begin
      viol      <= (rsn != RSN_OK);
      viol_code <= rsn;
    end
  end

  assign bank_open = open_v;
endmodule

// File: rtl/ddr_act_chk.sv
module ddr_act_chk #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [BANK_W-1:0]    bank,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic                 viol,
  input logic [2:0]           viol_code
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  logic is_act, is_pre, is_col;
  assign is_act = !cs_n && !ras_n &&  cas_n &&  we_n;
  assign is_pre = !cs_n && !ras_n &&  cas_n && !we_n;
  assign is_col = !cs_n &&  ras_n && !cas_n;

  // R1
  desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && cs_n |=> $stable(bank_open) && !viol);

  // R2
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && is_act |=> bank_open[$past(bank)]);

  // R3
  pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && is_pre && bank_open[bank] |=> !bank_open[$past(bank)]);

  // R4
  act_on_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && is_act && bank_open[bank] |=> viol && viol_code == 3'd1);

  // R9
  col_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && is_col && !bank_open[bank] |=> viol && viol_code == 3'd6);

  // R12
  flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol == (viol_code != 3'd0));
endmodule

bind ddr_act_timing_chk ddr_act_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_q), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .bank(bank), .bank_open(bank_open), .viol(viol), .viol_code(viol_code)
);

// File: tb/ddr_act_timing_chk_test.sv
`timescale 1ns/1ps
module ddr_act_timing_chk_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cs_n, ras_n, cas_n, we_n;
  logic [2:0] bank;
  logic [15:0] row;
  logic [4:0] cfg_trcd, cfg_tras, cfg_trp, cfg_trc, cfg_trrd;
  logic [2:0] cfg_al;
  logic viol;
  logic [2:0] viol_code;
  logic [7:0] bank_open;
  logic [127:0] bank_row;

  ddr_act_timing_chk uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .bank(bank), .row(row), .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
    .cfg_trc(cfg_trc), .cfg_trrd(cfg_trrd), .cfg_al(cfg_al),
    .viol(viol), .viol_code(viol_code), .bank_open(bank_open), .bank_row(bank_row)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  bit m_open [8];
  int m_act [8];
  int m_pre [8];
  logic [15:0] m_row [8];
  int m_any;
  int m_trcd, m_tras, m_trp, m_trc, m_trrd, m_al;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // cmd classes: 0 none, 1 act, 2 rd, 3 wr, 4 pre
  function automatic int classify(logic c, logic r, logic a, logic w);
    if (c) return 0;
    case ({r, a, w})
      3'b011: return 1;
      3'b101: return 2;
      3'b100: return 3;
      3'b010: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_rsn(int k, int b, int n);
    int al;
    al = (m_al > 4) ? 4 : m_al;
    case (k)
      1: begin
        if (m_open[b]) return 1;
        if (n - m_act[b] < m_trc) return 2;
        if (n - m_pre[b] < m_trp) return 3;
        if (n - m_any < m_trrd) return 4;
        return 0;
      end
      4: return (m_open[b] && (n - m_act[b] < m_tras)) ? 5 : 0;
      2, 3: begin
        if (!m_open[b]) return 6;
        if (n + al - m_act[b] < m_trcd) return 7;
        return 0;
      end
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(int e, int k);
    case (e)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R9";
      7: return "R10";
      default: return (k == 0) ? "R1" : "R12";
    endcase
  endfunction

  task automatic issue(logic c, logic r, logic a, logic w, int b, logic [15:0] rw);
    int k, e, n;
    logic [7:0] ov;
    cs_n = c; ras_n = r; cas_n = a; we_n = w; bank = 3'(b); row = rw;
    k = classify(c, r, a, w);
    n = cyc + 1;
    e = exp_rsn(k, b, n);
    @(posedge clk);
    cyc = n;
    if (k == 1) begin m_open[b] = 1; m_act[b] = n; m_any = n; m_row[b] = rw; end
    if (k == 4 && m_open[b]) begin m_open[b] = 0; m_pre[b] = n; end
    @(negedge clk);
    check(viol == (e != 0), req_of(e, k), "viol", int'(viol), int'(e != 0));
    check(viol_code == 3'(e), req_of(e, k), "viol_code", int'(viol_code), e);
    for (int i = 0; i < 8; i++) ov[i] = m_open[i];
    check(bank_open == ov, (k == 4) ? "R3" : "R2", "bank_open", int'(bank_open), int'(ov));
    if (k == 1)
      check(bank_row[b*16 +: 16] == rw, "R2", "bank_row", int'(bank_row[b*16 +: 16]), int'(rw));
  endtask

  task automatic act(int b, logic [15:0] rw); issue(0, 0, 1, 1, b, rw); endtask
  task automatic rd(int b);  issue(0, 1, 0, 1, b, 16'h0); endtask
  task automatic wr(int b);  issue(0, 1, 0, 0, b, 16'h0); endtask
  task automatic pre(int b); issue(0, 0, 1, 0, b, 16'h0); endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++)
      issue(1, 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 8), 16'($urandom));
  endtask

  task automatic do_reset(int trcd, int tras, int trp, int trc, int trrd, int al);
    rst_n = 0; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; bank = 0; row = 0;
    cfg_trcd = 5'(trcd); cfg_tras = 5'(tras); cfg_trp = 5'(trp);
    cfg_trc = 5'(trc); cfg_trrd = 5'(trrd); cfg_al = 3'(al);
    m_trcd = trcd; m_tras = tras; m_trp = trp; m_trc = trc; m_trrd = trrd; m_al = al;
    for (int i = 0; i < 8; i++) begin
      m_open[i] = 0; m_act[i] = -1000; m_pre[i] = -1000; m_row[i] = 0;
    end
    m_any = -1000; cyc = 0;
    repeat (3) @(negedge clk);
    check(bank_open == 8'h0 && viol == 1'b0, "R12", "reset state", int'({viol, bank_open}), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(bank_open == 8'h0 && viol_code == 3'd0, "R12", "after release", int'({viol_code, bank_open}), 0);
  endtask

  task automatic rand_ops(int n, int nb);
    for (int i = 0; i < n; i++) begin
      int r, b;
      r = int'($urandom % 10);
      b = int'($urandom % nb);
      case (r)
        0, 1:    idle(1);
        2:       issue(0, 1, 1, 1, b, 16'h0);
        3, 4, 5: act(b, 16'($urandom));
        6:       rd(b);
        7:       wr(b);
        default: pre(b);
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    // phase A: tRCD=3 AL=2 tRP=3 tRRD=2 tRAS=6 tRC=9
    do_reset(3, 6, 3, 9, 2, 2);
    act(0, 16'h1234);        // legal
    rd(0);                   // R10: 1+2 >= 3, legal
    act(1, 16'h00AA);        // R7 boundary: gap 2 legal
    act(2, 16'h0BB0);        // R7: gap 1 -> 4
    pre(0);                  // R8: 4 < 6 -> 5, still closes
    act(0, 16'h5555);        // R11: tRC and tRP both fail -> 2
    act(1, 16'h0777);        // R11: open and tRRD -> 1 (R4)
    idle(10);
    rd(5);                   // R9
    wr(7);                   // R9
    pre(6);                  // R3: closed bank, no effect
    pre(1);
    idle(2);
    act(1, 16'h0101);        // R6 boundary: gap exactly tRP
    pre(2); idle(1); act(2, 16'h2);  // R6: gap 2 < 3 -> 3
    issue(0, 1, 1, 1, 3, 16'h0);     // R1: NOP, no effect
    issue(0, 0, 0, 1, 3, 16'h0);     // R1: other pattern ignored
    rand_ops(1500, 4);

    // phase C: AL=6 clamps to 4, tRCD=6; then config inputs change (R13)
    do_reset(6, 1, 1, 1, 1, 6);
    cfg_trcd = 5'd1; cfg_al = 3'd0; cfg_trrd = 5'd20;
    act(3, 16'hCAFE);
    rd(3);                   // R10/R13: 1+4 < 6 -> 7
    rd(3);                   // 2+4 = 6, legal
    act(4, 16'hBEEF);        // R13: tRRD stays 1
    wr(4);                   // 1+4 < 6 -> 7
    // phase B: tRCD=4 AL=0
    do_reset(4, 5, 2, 7, 1, 0);
    act(2, 16'h0042);
    rd(2);                   // R10: 1 < 4 -> 7
    idle(2);
    wr(2);                   // R10 boundary: 4, legal
    rand_ops(800, 8);
    do_reset(2 + int'($urandom % 6), 3 + int'($urandom % 8), 1 + int'($urandom % 4),
             5 + int'($urandom % 10), 1 + int'($urandom % 3), int'($urandom % 5));
    rand_ops(1500, 3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule